// File: doc/BRIEF.md
# Buffered-Update PWM Timer Channel

A 16-bit counter with one output channel, driven by a period (modulo) value, a start value (initial count) and a channel compare value. The modulo and compare registers are double-buffered. A write while the counter runs only fills a holding buffer and raises a pending flag. The active copy is refreshed at a counter event that depends on the channel mode. While the clock select is zero the counter is frozen, and writes reach the active copies at once. The initial count is not buffered.

The counter sequencer has three named states. In STOP (clock select zero) the count holds. UP advances the count. DOWN exists only in center-aligned mode. The transitions are:
- STOP to UP when the clock select becomes nonzero.
- UP to DOWN on the turn event at the modulo value in center-aligned mode.
- DOWN to UP on a tick at the initial count, or as soon as the mode leaves center-aligned.
- Any state to STOP when the clock select returns to zero.

A run that starts from STOP begins in UP. An enhanced-mode bit hands modulo loading to an external synchronization scheme. That scheme is absent here, so with the bit set the modulo never loads on its own.

Top module: `pwm_shadow_timer`

## Requirements
- R1: With clk_sel = 0 the counter holds, and a write to the modulo or compare register updates the active value in the same clock, whatever enh_en is. Any nonzero clk_sel runs the counter.
- R2: Running in output-compare or edge-aligned mode with enh_en = 0, a pending modulo loads when the counter steps from the active modulo to the initial count. Until then the old modulo sets the wrap point.
- R3: When the initial count is 0 and the active modulo is 0x0000 or 0xFFFF, the counter is free-running: it counts to 0xFFFF and rolls to 0x0000, and pending modulo and edge-aligned compare values load at that roll.
- R4: In center-aligned mode (ch_mode = 2'b10) the counter counts up to the modulo, then down to the initial count, then up again. The step from the modulo to modulo minus one is the turn event, and pending modulo and compare values load there.
- R5: In output-compare mode (ch_mode = 2'b00) a pending compare value loads at the next counter step.
- R6: In edge-aligned mode (ch_mode = 2'b01 or 2'b11) a pending compare value loads at the wrap to the initial count.
- R7: With enh_en = 1 and the counter running, the modulo never loads automatically. Compare loading follows its mode rule.
- R8: An active value changes only if its pending flag was set. A running write sets the flag. When a write falls in the same clock as a load event, the active value takes the previously buffered value and the new value stays pending.
- R9: The counter steps once every 2^ps clocks (ps = 0..7).
- R10: Channel output: in edge-aligned mode it is high while count < compare. In center-aligned mode it is high while count <= compare. In output-compare mode it toggles when the counter steps onto the active compare value.
- R11: Register addresses are 0 = modulo, 1 = initial count, 2 = compare. Reads return the buffer (last written) value, and address 3 reads 0. A write to the initial count takes effect at once.
- R12: After reset the count is 0, the modulo is 0xFFFF, the initial count and compare are 0, the output-compare flop is low, and the sequencer is in STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Clock select; 0 stops the counter |
| ps | input | PS_W | Prescaler exponent, divide by 2^ps |
| enh_en | input | 1 | Enhanced mode: disables automatic modulo load |
| ch_mode | input | 2 | 00 output compare, 01/11 edge-aligned, 10 center-aligned |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Buffered register value |
| cnt_out | output | CNT_W | Counter value |
| ch_out | output | 1 | Channel output |

## Verification
The sharp collision is a register write landing on the same edge as the load event that would consume an earlier pending value. The bench provokes it in center-aligned mode by leaving one compare value pending, waiting until the count reads the modulo, and then writing a second value so that the write edge is the turn edge. The result is judged at the ports. The output right after the turn must reflect the older value, the read port must show the newer one, and the newer value must take effect only at the following turn. A reference model stepped every clock, fed by seeded random writes, mode changes and stops, also catches these coincidences, since writes often meet wraps and prescaler ticks.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;
    typedef enum logic [1:0] {
        MD_OC       = 2'b00,
        MD_EDGE     = 2'b01,
        MD_CENTER   = 2'b10,
        MD_EDGE_ALT = 2'b11
    } ch_mode_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'b00,
        ST_UP   = 2'b01,
        ST_DOWN = 2'b10
    } cnt_state_e;

    localparam logic [1:0] A_MOD  = 2'd0;
    localparam logic [1:0] A_INIT = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = DIV_W'((32'd1 << ps) - 32'd1);
        tick = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (run) pre_q <= pre_q + 1'b1;
        else          pre_q <= '0;
    end
endmodule

// File: rtl/pwm_shadow_reg.sv
`timescale 1ns/1ps
module pwm_shadow_reg #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stopped,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load_ev,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] act_q
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= RST_VAL;
            act_q  <= RST_VAL;
            pend_q <= 1'b0;
        end else if (wr && stopped) begin
            buf_q  <= wdata;
            act_q  <= wdata;
            pend_q <= 1'b0;
        end else begin
            if (load_ev && pend_q) act_q <= buf_q;
            if (wr) begin
                buf_q  <= wdata;
                pend_q <= 1'b1;
            end else if (load_ev && pend_q) begin
                pend_q <= 1'b0;
            end
        end
    end

    p_stop_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && wr) |=> (act_q == $past(wdata)));

    p_wr_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !stopped) |=> pend_q);

    p_hold_without_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && !pend_q) |=> $stable(act_q));
endmodule

// File: rtl/pwm_count_fsm.sv
`timescale 1ns/1ps
module pwm_count_fsm
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] mod_act,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap_ev,
    output logic             turn_ev
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    cnt_state_e st_q, st_d;
    logic       down, free_run, at_top;

    always_comb begin
        down     = (st_q == ST_DOWN) && center;
        free_run = (init_val == '0) && ((mod_act == '0) || (mod_act == ALL1));
        at_top   = free_run ? (cnt_q == ALL1) : (cnt_q == mod_act);
        wrap_ev  = tick && !down && !center && at_top;
        turn_ev  = tick && !down && center && (cnt_q == mod_act);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = ST_STOP;
        end else begin
            unique case (st_q)
                ST_STOP, ST_UP: st_d = turn_ev ? ST_DOWN : ST_UP;
                ST_DOWN: begin
                    if (!center)                          st_d = ST_UP;
                    else if (tick && (cnt_q == init_val)) st_d = ST_UP;
                end
                default: st_d = ST_STOP;
            endcase
        end
    end

    // count step
    always_comb begin
        cnt_nxt = cnt_q;
        if (tick) begin
            if (down)        cnt_nxt = (cnt_q == init_val) ? cnt_q + 1'b1 : cnt_q - 1'b1;
            else if (center) cnt_nxt = (cnt_q == mod_act)  ? cnt_q - 1'b1 : cnt_q + 1'b1;
            else             cnt_nxt = at_top ? init_val : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    p_wrap_to_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> (cnt_q == $past(init_val)));

    p_turn_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        turn_ev |=> (st_q == ST_DOWN));
endmodule

// File: rtl/pwm_shadow_timer.sv
`timescale 1ns/1ps
module pwm_shadow_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel,
    input  logic [PS_W-1:0]  ps,
    input  logic             enh_en,
    input  logic [1:0]       ch_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] cnt_out,
    output logic             ch_out
);
    ch_mode_e         mode_e;
    logic             run, stopped, tick, is_center;
    logic             wr_mod, wr_cmp, wr_init;
    logic             wrap_ev, turn_ev, mod_ld, cmp_ld;
    logic [CNT_W-1:0] mod_buf, mod_act, cmp_buf, cmp_act, init_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             oc_q;

    always_comb begin
        mode_e    = ch_mode_e'(ch_mode);
        run       = |clk_sel;
        stopped   = !run;
        is_center = (mode_e == MD_CENTER);
        wr_mod    = wr_en && (wr_addr == A_MOD);
        wr_init   = wr_en && (wr_addr == A_INIT);
        wr_cmp    = wr_en && (wr_addr == A_CMP);
        mod_ld    = !enh_en && (wrap_ev || turn_ev);
        unique case (mode_e)
            MD_OC:     cmp_ld = tick;
            MD_CENTER: cmp_ld = turn_ev;
            default:   cmp_ld = wrap_ev;
        endcase
    end

    pwm_prescale #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .ps(ps), .tick(tick)
    );

    pwm_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .center(is_center),
        .mod_act(mod_act), .init_val(init_q), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
        .wrap_ev(wrap_ev), .turn_ev(turn_ev)
    );

    pwm_shadow_reg #(.W(CNT_W), .RST_VAL('1)) u_mod (
        .clk(clk), .rst_n(rst_n), .stopped(stopped), .wr(wr_mod), .wdata(wr_data),
        .load_ev(mod_ld), .buf_q(mod_buf), .act_q(mod_act)
    );

    pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_cmp (
        .clk(clk), .rst_n(rst_n), .stopped(stopped), .wr(wr_cmp), .wdata(wr_data),
        .load_ev(cmp_ld), .buf_q(cmp_buf), .act_q(cmp_act)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       init_q <= '0;
        else if (wr_init) init_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            oc_q <= 1'b0;
        else if (tick && (cnt_nxt == cmp_act)) oc_q <= ~oc_q;
    end

    // outputs
    always_comb begin
        cnt_out = cnt_q;
        unique case (mode_e)
            MD_OC:     ch_out = oc_q;
            MD_CENTER: ch_out = (cnt_q <= cmp_act);
            default:   ch_out = (cnt_q < cmp_act);
        endcase
        unique case (rd_addr)
            A_MOD:   rd_data = mod_buf;
            A_INIT:  rd_data = init_q;
            A_CMP:   rd_data = cmp_buf;
            default: rd_data = '0;
        endcase
    end

    p_enh_mod_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en && run) |=> $stable(mod_act));
endmodule

// File: tb/pwm_shadow_timer_bench.sv
`timescale 1ns/1ps
module pwm_shadow_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic [2:0]  ps = 3'd0;
    logic        enh_en = 1'b0;
    logic [1:0]  ch_mode = 2'd1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data, cnt_out;
    logic        ch_out;

    always #10 clk = ~clk;

    pwm_shadow_timer u_pwm_shadow_timer (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ps(ps), .enh_en(enh_en),
        .ch_mode(ch_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_out(cnt_out), .ch_out(ch_out)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R12";

    // reference state
    logic [15:0] e_cnt = 0, e_mod = 16'hFFFF, e_modb = 16'hFFFF, e_init = 0, e_cv = 0, e_cvb = 0;
    bit          e_modp = 0, e_cvp = 0, e_dn = 0, e_oc = 0;
    int          e_pre = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ch();
        if (ch_mode == 2'b00) return e_oc;
        if (ch_mode == 2'b10) return (e_cnt <= e_cv);
        return (e_cnt < e_cv);
    endfunction

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return e_modb;
            2'd1: return e_init;
            2'd2: return e_cvb;
            default: return 16'd0;
        endcase
    endfunction

    task automatic model_edge();
        bit run, tk, cen, ocm, edg, goes_down, free, at_end, wrap, turn, mload, cload;
        int mask;
        logic [15:0] nxt;
        if (!rst_n) begin
            e_cnt = 0; e_mod = 16'hFFFF; e_modb = 16'hFFFF; e_init = 0;
            e_cv = 0; e_cvb = 0; e_modp = 0; e_cvp = 0; e_dn = 0; e_oc = 0; e_pre = 0;
            return;
        end
        run  = (clk_sel != 2'd0);
        mask = (1 << ps) - 1;
        tk   = run && ((e_pre & mask) == mask);
        cen  = (ch_mode == 2'b10);
        ocm  = (ch_mode == 2'b00);
        edg  = !cen && !ocm;
        goes_down = e_dn && cen;
        free = (e_init == 0) && (e_mod == 16'h0000 || e_mod == 16'hFFFF);
        at_end = free ? (e_cnt == 16'hFFFF) : (e_cnt == e_mod);
        wrap = tk && !goes_down && !cen && at_end;
        turn = tk && !goes_down && cen && (e_cnt == e_mod);
        nxt = e_cnt;
        if (tk) begin
            if (goes_down) nxt = (e_cnt == e_init) ? e_cnt + 16'd1 : e_cnt - 16'd1;
            else if (cen)  nxt = turn ? e_cnt - 16'd1 : e_cnt + 16'd1;
            else           nxt = wrap ? e_init : e_cnt + 16'd1;
        end
        if (!run || !cen) e_dn = 0;
        else if (turn) e_dn = 1;
        else if (goes_down && tk && e_cnt == e_init) e_dn = 0;
        if (tk && nxt == e_cv) e_oc = !e_oc;
        mload = e_modp && !enh_en && (wrap || turn);
        cload = e_cvp && (ocm ? tk : (edg ? wrap : turn));
        if (mload) begin e_mod = e_modb; e_modp = 0; end
        if (cload) begin e_cv = e_cvb; e_cvp = 0; end
        if (wr_en) begin
            case (wr_addr)
                2'd0: begin e_modb = wr_data; if (run) e_modp = 1; else begin e_mod = wr_data; e_modp = 0; end end
                2'd1: e_init = wr_data;
                2'd2: begin e_cvb = wr_data; if (run) e_cvp = 1; else begin e_cv = wr_data; e_cvp = 0; end end
                default: ;
            endcase
        end
        e_pre = run ? ((e_pre + 1) & 127) : 0;
        e_cnt = nxt;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "model cnt_out", int'(cnt_out), int'(e_cnt));
        chk(tag, "model ch_out", int'(ch_out), int'(exp_ch()));
        chk("R11", "model rd_data", int'(rd_data), int'(exp_rd(rd_addr)));
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; clk_sel = 2'd0; ps = 3'd0; enh_en = 1'b0; wr_en = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        for (int i = 0; i < 300 && cnt_out != v; i++) cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int prev, steps, mx;
        // R12 reset
        tag = "R12";
        reset_dut();
        rd_addr = 2'd0;
        chk("R12", "cnt after reset", int'(cnt_out), 0);
        chk("R12", "ch after reset", int'(ch_out), 0);
        chk("R12", "modulo after reset", int'(rd_data), 16'hFFFF);

        // R1 stopped writes immediate, enh ignored
        tag = "R1";
        ch_mode = 2'b01; enh_en = 1'b1;
        wr(2'd0, 16'd9);
        wr(2'd2, 16'd4);
        chk("R11", "modulo buffer read", int'(rd_data), 9);
        chk("R1", "ch high from immediate compare", int'(ch_out), 1);
        enh_en = 1'b0; clk_sel = 2'd1;
        repeat (9) cyc();
        chk("R1", "count at immediate modulo", int'(cnt_out), 9);
        cyc();
        chk("R1", "wrap after immediate modulo", int'(cnt_out), 0);

        // R2 / R6 buffered loads at wrap
        tag = "R2";
        wr(2'd0, 16'd5);
        wr(2'd2, 16'd2);
        repeat (7) cyc();
        chk("R2", "old modulo still rules", int'(cnt_out), 9);
        chk("R6", "old compare still rules", int'(ch_out), 0);
        chk("R11", "read returns pending modulo", int'(rd_data), 5);
        tag = "R6";
        cyc();
        chk("R6", "ch at init after wrap", int'(ch_out), 1);
        repeat (3) cyc();
        chk("R6", "new compare active", int'(ch_out), 0);
        repeat (2) cyc();
        chk("R2", "count at new modulo", int'(cnt_out), 5);
        cyc();
        chk("R2", "wrap at new modulo", int'(cnt_out), 0);

        // R9 prescaler
        tag = "R9";
        ps = 3'd2;
        prev = int'(cnt_out); steps = 0;
        for (int i = 0; i < 16; i++) begin
            cyc();
            if (int'(cnt_out) != prev) steps++;
            prev = int'(cnt_out);
        end
        chk("R9", "steps in 16 clocks at ps=2", steps, 4);
        ps = 3'd0;

        // R5 output compare loads at next step
        tag = "R5";
        reset_dut();
        ch_mode = 2'b00;
        wr(2'd0, 16'd30);
        wr(2'd2, 16'd7);
        clk_sel = 2'd1;
        wr(2'd2, 16'd12);
        repeat (10) cyc();
        chk("R5", "no toggle at old compare", int'(ch_out), 0);
        cyc();
        chk("R10", "oc toggles on reaching compare", int'(ch_out), 1);
        chk("R5", "count at compare", int'(cnt_out), 12);

        // R4 center-aligned
        tag = "R4";
        reset_dut();
        ch_mode = 2'b10;
        wr(2'd0, 16'd6);
        wr(2'd2, 16'd3);
        clk_sel = 2'd1;
        repeat (6) cyc();
        chk("R4", "up to modulo", int'(cnt_out), 6);
        cyc();
        chk("R4", "turn to modulo-1", int'(cnt_out), 5);
        chk("R10", "center ch low above compare", int'(ch_out), 0);
        repeat (2) cyc();
        chk("R10", "center ch high at compare", int'(ch_out), 1);
        repeat (3) cyc();
        chk("R4", "down to initial", int'(cnt_out), 0);
        cyc();
        chk("R4", "back up", int'(cnt_out), 1);

        // R8 write coincides with turn load
        tag = "R8";
        rd_addr = 2'd2;
        wr(2'd2, 16'd2);
        wait_cnt(16'd6);
        wr(2'd2, 16'd5);
        chk("R8", "count after turn", int'(cnt_out), 5);
        chk("R8", "older value loaded", int'(ch_out), 0);
        chk("R8", "newer value buffered", int'(rd_data), 5);
        repeat (2) cyc();
        chk("R8", "older compare still active", int'(ch_out), 0);
        wait_cnt(16'd6);
        cyc();
        chk("R4", "newer compare loads at next turn", int'(ch_out), 1);
        tag = "R4";
        wr(2'd0, 16'd4);
        repeat (30) cyc();

        // R7 enhanced mode blocks modulo load
        tag = "R7";
        reset_dut();
        rd_addr = 2'd0;
        ch_mode = 2'b01;
        wr(2'd0, 16'd8);
        enh_en = 1'b1; clk_sel = 2'd1;
        wr(2'd0, 16'd4);
        wr(2'd2, 16'd3);
        mx = 0;
        for (int i = 0; i < 30; i++) begin
            cyc();
            if (int'(cnt_out) > mx) mx = int'(cnt_out);
        end
        chk("R7", "modulo not loaded with enh", mx, 8);
        chk("R7", "pending modulo readable", int'(rd_data), 4);
        enh_en = 1'b0;
        repeat (30) cyc();

        // R3 free-running roll
        tag = "R3";
        reset_dut();
        ch_mode = 2'b01;
        wr(2'd0, 16'd0);
        clk_sel = 2'd1;
        wr(2'd0, 16'd50);
        wr(2'd2, 16'd10);
        repeat (65533) cyc();
        chk("R3", "count reaches 0xFFFF", int'(cnt_out), 16'hFFFF);
        chk("R3", "old compare before roll", int'(ch_out), 0);
        cyc();
        chk("R3", "roll to zero", int'(cnt_out), 0);
        chk("R3", "compare loaded at roll", int'(ch_out), 1);
        repeat (50) cyc();
        chk("R3", "count at loaded modulo", int'(cnt_out), 50);
        cyc();
        chk("R3", "wrap at loaded modulo", int'(cnt_out), 0);

        // R10 random mix against reference
        tag = "R10";
        reset_dut();
        void'($urandom(32'd24681));
        wr(2'd0, 16'd12);
        clk_sel = 2'd1;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 59) == 0) ch_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 39) == 0) clk_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 79) == 0) enh_en = ~enh_en;
            if ($urandom_range(0, 49) == 0) ps = 3'($urandom_range(0, 1));
            rd_addr = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) begin
                wr_en = 1'b1;
                wr_addr = 2'($urandom_range(0, 2));
                case (wr_addr)
                    2'd0: wr_data = 16'($urandom_range(3, 24));
                    2'd1: wr_data = 16'($urandom_range(0, 2));
                    default: wr_data = 16'($urandom_range(0, 26));
                endcase
            end
            cyc();
            wr_en = 1'b0;
        end
        finish_run();
    end
endmodule